// File: doc/BRIEF.md
# Addressed Serial DAC Control Port

This block is the receiving side of a write-only three-wire control link made of a data line, a gated serial clock and a load strobe. Each transfer is a 10-bit word. Its two top bits form an address that picks one of four targets. Two targets are 8-bit holding latches that feed two serial DAC output registers. The other two are offset-trim registers for two parallel DACs. A rising edge on the strobe decodes the word held at that moment and copies both holding latches into the output registers in one system cycle.

The serial inputs run far slower than the system clock. They pass through two-flop synchronizers and all edges are detected after synchronization. For each parallel DAC the block also drives a signed offset. This value comes either from a factory trim input or from the value that software last wrote. The link has no flow control, because the sender owns the pacing. For that reason the pins are plain control pins and not a valid/ready stream.

Top module: `sdac_ctrl_port`

## Requirements
- R1: While reset is asserted, and after it is released, both DAC codes are 0 and both offsets follow their factory trim inputs.
- R2: Each rising edge of the synchronized serial clock shifts the synchronized data bit into the LSB, so the word is sent MSB first. Only the last 10 bits are kept. The bit counter saturates at 11.
- R3: A valid word with bits 9:8 = 10 writes bits 7:0 into the DAC0 holding latch, and 01 writes the DAC1 latch. On every strobe both output registers load their holding latches, including a write made at that same strobe. The latch that was not addressed keeps its value.
- R4: A valid word with bits 9:8 = 00 writes the A offset register, and 11 writes the B register. Bits 7:6 are ignored. Bit 5 = 1 selects the user value and bit 5 = 0 selects the factory trim. The effective offset is a 5-bit two's-complement value: +magnitude when the direction bit is 1 and −magnitude when it is 0. For a user write the direction is bit 4 and the magnitude is bits 3:0. For factory trim the input is {direction, magnitude[3:0]}. Factory trim changes are passed to the output while factory is selected.
- R5: A word is valid only when exactly 10 bits arrived since the last strobe. A strobe that comes after fewer or more bits leaves all holding latches and offset registers unchanged.
- R6: The bit counter clears on every strobe, so bits from an earlier invalid burst do not count toward the next word.
- R7: While the power-down input is low, both DAC output codes are forced to 0. The holding latches keep their contents and can still be written.
- R8: The DAC output codes change only on a strobe or on power-down. Serial bits without a strobe, and the release of power-down, leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Gated serial clock, idles low |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_stb | input | 1 | Load strobe, active on its rising edge |
| sdac_pwr_n | input | 1 | Serial DAC power-down, active low |
| fac_trim_a | input | 5 | Factory trim A: {direction, magnitude} |
| fac_trim_b | input | 5 | Factory trim B: {direction, magnitude} |
| dac0_code | output | 8 | DAC0 output register |
| dac1_code | output | 8 | DAC1 output register |
| offs_a | output | 5 | Effective signed offset A |
| offs_b | output | 5 | Effective signed offset B |

## Verification
On a strobe, the decode that writes a holding latch and the transfer into the output registers happen in the same cycle. The bench shows this by sending a single valid word and then one strobe, with no second strobe. It then checks that the addressed output already shows the new code while the other output keeps its old value. A second meeting point is a strobe that falls right after a burst of the wrong length. This is provoked with 9-bit and 11-bit bursts, and with a 6-bit burst followed by a correct word. In each case the bench checks that the transfer still takes place and the decode does not.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int ADDR_W  = 2;
  localparam int CODE_DW = 8;
  localparam int MAG_DW  = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADR_OFS_A = 2'b00,
    ADR_DAC1  = 2'b01,
    ADR_DAC0  = 2'b10,
    ADR_OFS_B = 2'b11
  } sdac_addr_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shift_rx.sv
module sdac_shift_rx #(
  parameter int WORD_W = 10,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              clr,
  output logic [WORD_W-1:0] word,
  output logic              word_ok,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic sclk_q;
  logic sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      word    <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (sclk_rise) word <= {word[WORD_W-2:0], sdat_s};
      if (clr)
        bit_cnt <= '0;
      else if (sclk_rise && bit_cnt != CNT_SAT)
        bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign word_ok = (bit_cnt == CNT_FULL);
endmodule

// File: rtl/sdac_word_decode.sv
module sdac_word_decode
  import sdac_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int MAG_W  = 4,
  localparam int WORD_W = ADDR_W + CODE_W,
  localparam int OFS_W  = MAG_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              word_ok,
  input  logic              stb,
  input  logic              pwr_n_s,
  output logic [CODE_W-1:0] dac0_q,
  output logic [CODE_W-1:0] dac1_q,
  output logic [OFS_W-1:0]  ofs_a_q,
  output logic [OFS_W-1:0]  ofs_b_q
);
  sdac_addr_e        adr;
  logic              wr_en;
  logic [CODE_W-1:0] hold_q  [2];
  logic [CODE_W-1:0] hold_nx [2];
  logic [OFS_W-1:0]  ofs_a_nx;
  logic [OFS_W-1:0]  ofs_b_nx;

  assign adr   = sdac_addr_e'(word[WORD_W-1 -: ADDR_W]);
  assign wr_en = stb & word_ok;

  always_comb begin
    hold_nx[0] = hold_q[0];
    hold_nx[1] = hold_q[1];
    ofs_a_nx   = ofs_a_q;
    ofs_b_nx   = ofs_b_q;
    if (wr_en) begin
      unique case (adr)
        ADR_DAC0:  hold_nx[0] = word[CODE_W-1:0];
        ADR_DAC1:  hold_nx[1] = word[CODE_W-1:0];
        ADR_OFS_A: ofs_a_nx   = word[OFS_W-1:0];
        ADR_OFS_B: ofs_b_nx   = word[OFS_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q[c] <= '0;
      else        hold_q[c] <= hold_nx[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_a_q <= '0;
      ofs_b_q <= '0;
    end else begin
      ofs_a_q <= ofs_a_nx;
      ofs_b_q <= ofs_b_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac0_q <= '0;
      dac1_q <= '0;
    end else if (!pwr_n_s) begin
      dac0_q <= '0;
      dac1_q <= '0;
    end else if (stb) begin
      dac0_q <= hold_nx[0];
      dac1_q <= hold_nx[1];
    end
  end
endmodule

// File: rtl/sdac_offset_sel.sv
module sdac_offset_sel #(
  parameter int MAG_W = 4,
  localparam int OFS_W = MAG_W + 2
) (
  input  logic [OFS_W-1:0] reg_q,
  input  logic [MAG_W:0]   fac,
  output logic [MAG_W:0]   offs
);
  logic              use_user;
  logic              up;
  logic [MAG_W-1:0]  mag;
  logic signed [MAG_W:0] mag_s;

  assign use_user = reg_q[MAG_W+1];
  assign up       = use_user ? reg_q[MAG_W] : fac[MAG_W];
  assign mag      = use_user ? reg_q[MAG_W-1:0] : fac[MAG_W-1:0];
  assign mag_s    = {1'b0, mag};
  assign offs     = up ? mag_s : -mag_s;
endmodule

// File: rtl/sdac_ctrl_port.sv
module sdac_ctrl_port
  import sdac_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int MAG_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_stb,
  input  logic              sdac_pwr_n,
  input  logic [MAG_W:0]    fac_trim_a,
  input  logic [MAG_W:0]    fac_trim_b,
  output logic [CODE_W-1:0] dac0_code,
  output logic [CODE_W-1:0] dac1_code,
  output logic [MAG_W:0]    offs_a,
  output logic [MAG_W:0]    offs_b
);
  localparam int WORD_W = ADDR_W + CODE_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam int OFS_W  = MAG_W + 2;

  logic [3:0]        raw_in;
  logic [3:0]        sync_out;
  logic              sclk_s, sdat_s, stb_s, pwr_n_s;
  logic              stb_q, stb_pulse;
  logic [WORD_W-1:0] word;
  logic              word_ok;
  logic [CNT_W-1:0]  bit_cnt;
  logic [OFS_W-1:0]  ofs_a_r, ofs_b_r;

  assign raw_in = {sdac_pwr_n, ser_stb, ser_dat, ser_clk};
  assign {pwr_n_s, stb_s, sdat_s, sclk_s} = sync_out;

  sdac_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_s;
  end
  assign stb_pulse = stb_s & ~stb_q;

  sdac_shift_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sdat_s(sdat_s),
    .clr(stb_pulse), .word(word), .word_ok(word_ok), .bit_cnt(bit_cnt)
  );

  sdac_word_decode #(.CODE_W(CODE_W), .MAG_W(MAG_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .word(word), .word_ok(word_ok),
    .stb(stb_pulse), .pwr_n_s(pwr_n_s),
    .dac0_q(dac0_code), .dac1_q(dac1_code),
    .ofs_a_q(ofs_a_r), .ofs_b_q(ofs_b_r)
  );

  sdac_offset_sel #(.MAG_W(MAG_W)) u_sel_a (
    .reg_q(ofs_a_r), .fac(fac_trim_a), .offs(offs_a)
  );
  sdac_offset_sel #(.MAG_W(MAG_W)) u_sel_b (
    .reg_q(ofs_b_r), .fac(fac_trim_b), .offs(offs_b)
  );
endmodule

// File: rtl/sdac_ctrl_port_chk.sv
module sdac_ctrl_port_chk #(
  parameter int CODE_W = 8,
  parameter int MAG_W  = 4,
  parameter int CNT_W  = 4,
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_n_s,
  input logic              stb_pulse,
  input logic              word_ok,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CODE_W-1:0] dac0_code,
  input logic [CODE_W-1:0] dac1_code,
  input logic [MAG_W:0]    offs_a,
  input logic [MAG_W:0]    offs_b,
  input logic [MAG_W+1:0]  ofs_a_r,
  input logic [MAG_W+1:0]  ofs_b_r
);
  localparam logic [MAG_W:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  assert_cnt_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W + 1));

  assert_offs_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    offs_a != MOST_NEG && offs_b != MOST_NEG);

  assert_bad_word_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_pulse && !word_ok) |=> ($stable(ofs_a_r) && $stable(ofs_b_r)));

  assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_pulse |=> bit_cnt == '0);

  assert_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n_s |=> (dac0_code == '0 && dac1_code == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n_s && !stb_pulse) |=> ($stable(dac0_code) && $stable(dac1_code)));
endmodule

bind sdac_ctrl_port sdac_ctrl_port_chk #(
  .CODE_W(CODE_W), .MAG_W(MAG_W), .CNT_W(CNT_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_n_s(pwr_n_s), .stb_pulse(stb_pulse),
  .word_ok(word_ok), .bit_cnt(bit_cnt), .dac0_code(dac0_code),
  .dac1_code(dac1_code), .offs_a(offs_a), .offs_b(offs_b),
  .ofs_a_r(ofs_a_r), .ofs_b_r(ofs_b_r)
);

// File: tb/tb_sdac_ctrl_port.sv
module tb_sdac_ctrl_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0;
  logic       sdac_pwr_n = 1'b1;
  logic [4:0] fac_trim_a = 5'b1_0101;  // +5
  logic [4:0] fac_trim_b = 5'b0_0011;  // -3
  logic [7:0] dac0_code, dac1_code;
  logic [4:0] offs_a, offs_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sdac_ctrl_port dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_stb(ser_stb), .sdac_pwr_n(sdac_pwr_n), .fac_trim_a(fac_trim_a),
    .fac_trim_b(fac_trim_b), .dac0_code(dac0_code), .dac1_code(dac1_code),
    .offs_a(offs_a), .offs_b(offs_b)
  );

  typedef struct packed {
    logic [9:0] w;
    logic [3:0] n;
    logic [3:0] req;
    logic [7:0] d0, d1;
    logic [4:0] oa, ob;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{10'h2A5, 4'd10, 4'd3, 8'hA5, 8'h00, 5'h05, 5'h1D},  // R3 DAC0
    '{10'h13C, 4'd10, 4'd3, 8'hA5, 8'h3C, 5'h05, 5'h1D},  // R3 DAC1
    '{10'h0F9, 4'd10, 4'd4, 8'hA5, 8'h3C, 5'h09, 5'h1D},  // R4 user +9, bits 7:6 set
    '{10'h327, 4'd10, 4'd4, 8'hA5, 8'h3C, 5'h09, 5'h19},  // R4 user -7
    '{10'h2FF, 4'd9,  4'd5, 8'hA5, 8'h3C, 5'h09, 5'h19},  // R5 short burst
    '{10'h2FF, 4'd11, 4'd5, 8'hA5, 8'h3C, 5'h09, 5'h19},  // R5 long burst
    '{10'h200, 4'd10, 4'd3, 8'h00, 8'h3C, 5'h09, 5'h19},
    '{10'h01F, 4'd10, 4'd4, 8'h00, 8'h3C, 5'h05, 5'h19},  // R4 back to factory
    '{10'h3B0, 4'd10, 4'd4, 8'h00, 8'h3C, 5'h05, 5'h00},  // R4 user +0
    '{10'h1FF, 4'd10, 4'd3, 8'h00, 8'hFF, 5'h05, 5'h00},
    '{10'h280, 4'd10, 4'd3, 8'h80, 8'hFF, 5'h05, 5'h00},
    '{10'h300, 4'd10, 4'd4, 8'h80, 8'hFF, 5'h05, 5'h1D}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_bits(input logic [9:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(i < 10 ? w[i] : 1'b1);
    ser_dat = 1'b0;
    wait_clk(4);
  endtask

  task automatic strobe();
    ser_stb = 1'b1;
    wait_clk(4);
    ser_stb = 1'b0;
    wait_clk(6);
  endtask

  task automatic check_all(input string tag, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [4:0] oa, input logic [4:0] ob);
    chk({tag, " dac0"}, dac0_code, d0);
    chk({tag, " dac1"}, dac1_code, d1);
    chk({tag, " offs_a"}, {3'b0, offs_a}, {3'b0, oa});
    chk({tag, " offs_b"}, {3'b0, offs_b}, {3'b0, ob});
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    check_all("R1 in reset", 8'h00, 8'h00, 5'h05, 5'h1D);
    rst_n = 1'b1;
    wait_clk(5);
    check_all("R1 after reset", 8'h00, 8'h00, 5'h05, 5'h1D);

    for (int v = 0; v < NV; v++) begin
      send_bits(VECS[v].w, int'(VECS[v].n));
      strobe();
      check_all($sformatf("R%0d row %0d", VECS[v].req, v),
                VECS[v].d0, VECS[v].d1, VECS[v].oa, VECS[v].ob);
    end

    // R5: strobe with no bits at all
    strobe();
    check_all("R5 empty strobe", 8'h80, 8'hFF, 5'h05, 5'h1D);

    // R6: invalid 6-bit burst, then a correct word must still be taken
    send_bits(10'h3FF, 6);
    strobe();
    send_bits(10'h142, 10);
    strobe();
    check_all("R6 counter cleared", 8'h80, 8'h42, 5'h05, 5'h1D);

    // R8: a word without strobe leaves the outputs alone
    send_bits(10'h211, 10);
    wait_clk(10);
    chk("R8 no strobe dac0", dac0_code, 8'h80);
    strobe();
    chk("R3 strobe dac0", dac0_code, 8'h11);

    // R7: power-down forces standby, holding latches keep working
    sdac_pwr_n = 1'b0;
    wait_clk(6);
    chk("R7 standby dac0", dac0_code, 8'h00);
    chk("R7 standby dac1", dac1_code, 8'h00);
    send_bits(10'h155, 10);
    strobe();
    chk("R7 write in standby dac1", dac1_code, 8'h00);
    sdac_pwr_n = 1'b1;
    wait_clk(8);
    chk("R8 power-up no strobe dac0", dac0_code, 8'h00);
    strobe();
    chk("R7 restored dac0", dac0_code, 8'h11);
    chk("R7 restored dac1", dac1_code, 8'h55);

    // R4: factory trim followed while factory is selected
    fac_trim_a = 5'b0_0010;  // -2
    wait_clk(2);
    chk("R4 factory follow a", {3'b0, offs_a}, 8'h1E);
    chk("R4 factory b", {3'b0, offs_b}, 8'h1D);

    // R1: reset mid-run
    send_bits(10'h0FF, 10);
    strobe();
    chk("R4 user a before reset", {3'b0, offs_a}, 8'h0F);
    rst_n = 1'b0;
    wait_clk(2);
    check_all("R1 mid-run reset", 8'h00, 8'h00, 5'h1E, 5'h1D);
    rst_n = 1'b1;
    wait_clk(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule